// File: doc/BRIEF.md
# PHY Tuning Read-Modify-Write Sequencer

This block applies a fixed list of tuning adjustments to a PHY's internal control registers once the PHY has come out of reset. Each adjustment is one read-modify-write: the register is read, a clear mask takes bits out, a set value puts bits in, and the result is written back. Bits outside both masks keep the value the PHY reported. The list is a constant table built into the block, so no software takes part and no storage can be programmed.

The PHY's control registers sit behind a narrow strobe/acknowledge bus. A single word bus carries the address, the write data or nothing. Four strobes name the transfer: address capture, data capture, read and write. Every strobe is a full four-phase handshake. The strobe rises, the PHY raises its acknowledge, the strobe falls, and the PHY then drops its acknowledge. An internal bus master runs these handshakes. The sequencer above it runs the reads, merges and writes for each entry.

A one-cycle `start` pulse launches the script from its first entry. `finished` pulses for one cycle once the last write has fully completed its handshake. A `start` that arrives while the script is running is ignored. A `start` that arrives after `finished` runs the whole script again.

Top module: `phy_tune_seq`

## Requirements
- R1: In reset and after it, with no `start`, all four strobes and `finished` are low.
- R2: The script touches registers in the fixed order 0x102D, 0x1010, 0x1006, 0x1002, 0x0030, with exactly one write per register per run.
- R3: The written value is (read & ~clear) | set, using the value read in the same entry. The (clear, set) pairs are: 0x102D (0x0000, 0x0080); 0x1010 (0x0FF0, 0x0020); 0x1006 (0x0740, 0x0B80); 0x1002 (0x3FFF, 0x4B7F); 0x0030 (0x00F0, 0x0000).
- R4: At most one strobe is high at a time. A raised strobe and the word bus hold steady until the acknowledge rises. The strobe then falls, and no strobe rises again until the acknowledge is low.
- R5: Each entry runs in this order: address capture, read, address capture, data capture carrying the merged value, write.
- R6: `finished` is a single-cycle pulse. It comes exactly once per run, after the last write handshake has completed.
- R7: A `start` pulse while a run is in progress has no effect: it causes no extra writes and no extra `finished`.
- R8: A `start` pulse after `finished` runs the script again from the first entry.
- R9: The bus word is 16 bits. Strobe bit order inside the bus master is address capture, data capture, read, write (bit 0 to bit 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the script |
| finished | output | 1 | One-cycle pulse after the final write |
| phy_word | output | 16 | Address or write data to the PHY |
| phy_addr_stb | output | 1 | Address capture strobe |
| phy_data_stb | output | 1 | Data capture strobe |
| phy_rd_stb | output | 1 | Read strobe |
| phy_wr_stb | output | 1 | Write strobe |
| phy_ack | input | 1 | Handshake acknowledge from the PHY |
| phy_rdata | input | 16 | Read data, valid while acknowledge is high after a read |

## Verification
The register model is preset to all zeros, to all ones and to several random words from a fixed seed. All zeros shows whether the set values arrive. All ones shows whether the clear masks act. The random words show whether untouched bits survive, which catches a write of a constant in place of the merged value. The model's acknowledge delays vary at random from zero to three cycles to stress the handshake. A `start` is also pulsed in the middle of a run, and runs are repeated back to back, so that ignored starts and reruns show up in the count of writes and of `finished` pulses.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned SCRIPT_LEN = 5;

    // strobe vector bit positions follow this enum (R9)
    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_DATA  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        STEP_RADDR = 3'd0,
        STEP_READ  = 3'd1,
        STEP_WADDR = 3'd2,
        STEP_WDATA = 3'd3,
        STEP_WRITE = 3'd4
    } rmw_step_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] clr;
        logic [WORD_W-1:0] set;
    } rmw_entry_t;

    function automatic rmw_entry_t script_entry(input int idx);
        rmw_entry_t e;
        case (idx)
            0:       e = '{addr: 16'h102D, clr: 16'h0000, set: 16'h0080};
            1:       e = '{addr: 16'h1010, clr: 16'h0FF0, set: 16'h0020};
            2:       e = '{addr: 16'h1006, clr: 16'h0740, set: 16'h0B80};
            3:       e = '{addr: 16'h1002, clr: 16'h3FFF, set: 16'h4B7F};
            default: e = '{addr: 16'h0030, clr: 16'h00F0, set: 16'h0000};
        endcase
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old,
                                                     input rmw_entry_t e);
        return (old & ~e.clr) | e.set;
    endfunction

    function automatic bus_op_e step_op(input rmw_step_e s);
        case (s)
            STEP_READ:  return OP_READ;
            STEP_WDATA: return OP_DATA;
            STEP_WRITE: return OP_WRITE;
            default:    return OP_ADDR;
        endcase
    endfunction

endpackage

// File: rtl/tune_script_rom.sv
module tune_script_rom
    import phy_tune_pkg::*;
#(
    parameter int unsigned ENTRIES = SCRIPT_LEN,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output rmw_entry_t       entry
);
    rmw_entry_t table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
        assign table_q[g] = script_entry(g);
    end

    always_comb begin
        entry = table_q[0];
        for (int i = 0; i < ENTRIES; i++) begin
            if (idx == IDX_W'(i)) entry = table_q[i];
        end
    end
endmodule

// File: rtl/cr_bus_master.sv
module cr_bus_master
    import phy_tune_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  bus_op_e      cmd_op,
    input  logic [W-1:0] cmd_word,
    output logic         cmd_ready,
    output logic         op_done,
    output logic [W-1:0] rd_word,
    output logic [W-1:0] bus_word,
    output logic [3:0]   bus_stb,
    input  logic         bus_ack,
    input  logic [W-1:0] bus_rdata
);
    typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_e;
    phase_e       phase;
    logic [W-1:0] word_q, rd_q;
    logic [3:0]   stb_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            word_q <= '0;
            rd_q   <= '0;
            stb_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: if (cmd_valid) begin
                    word_q <= cmd_word;
                    stb_q  <= 4'(1) << cmd_op;
                    phase  <= PH_HIGH;
                end
                PH_HIGH: if (bus_ack) begin
                    rd_q  <= bus_rdata;
                    stb_q <= '0;
                    phase <= PH_LOW;
                end
                default: if (!bus_ack) begin
                    done_q <= 1'b1;
                    phase  <= PH_IDLE;
                end
            endcase
        end
    end

    assign cmd_ready = (phase == PH_IDLE);
    assign op_done   = done_q;
    assign rd_word   = rd_q;
    assign bus_word  = word_q;
    assign bus_stb   = stb_q;

    // R4: one strobe at a time
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb_q));
    // R4: strobe and word held until acknowledge
    p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (|stb_q && !bus_ack) |=> ($stable(stb_q) && $stable(word_q)));
    // R4: strobe falls once acknowledged
    p_drop_on_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (|stb_q && bus_ack) |=> (stb_q == 4'b0));
    // R4: new strobe only after acknowledge low
    p_rise_ack_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(|stb_q) |-> !$past(bus_ack));
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
    import phy_tune_pkg::*;
#(
    parameter int unsigned ENTRIES = SCRIPT_LEN,
    parameter int unsigned W       = WORD_W,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             finished,
    output logic [IDX_W-1:0] entry_idx,
    input  rmw_entry_t       entry,
    output logic             cmd_valid,
    output bus_op_e          cmd_op,
    output logic [W-1:0]     cmd_word,
    input  logic             cmd_ready,
    input  logic             op_done,
    input  logic [W-1:0]     rd_word
);
    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_e;
    seq_state_e       state;
    rmw_step_e        step;
    logic [IDX_W-1:0] idx_q;
    logic [W-1:0]     read_q;
    logic             fin_q;
    logic [W-1:0]     merged;
    logic             last_entry;

    assign merged     = merge_word(read_q, entry);
    assign last_entry = (idx_q == IDX_W'(ENTRIES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            step   <= STEP_RADDR;
            idx_q  <= '0;
            read_q <= '0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    idx_q <= '0;
                    step  <= STEP_RADDR;
                    state <= SQ_ISSUE;
                end
                SQ_ISSUE: state <= SQ_WAIT;
                default: if (op_done) begin
                    if (step == STEP_READ) read_q <= rd_word;
                    if (step == STEP_WRITE) begin
                        step <= STEP_RADDR;
                        if (last_entry) begin
                            fin_q <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end else begin
                        step  <= rmw_step_e'(step + 3'd1);
                        state <= SQ_ISSUE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        cmd_valid = (state == SQ_ISSUE);
        cmd_op    = step_op(step);
        case (step)
            STEP_WDATA, STEP_WRITE: cmd_word = merged;
            default:                cmd_word = entry.addr;
        endcase
    end

    assign finished  = fin_q;
    assign entry_idx = idx_q;

    // R6: finished lasts one cycle
    p_finish_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q);
    // R4: commands only go to an idle bus master
    p_cmd_when_ready_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_ready);
    // R7: a running script keeps its entry index across a start pulse
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT && start && !op_done) |=> $stable(idx_q));
endmodule

// File: rtl/phy_tune_seq.sv
module phy_tune_seq
    import phy_tune_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              finished,
    output logic [WORD_W-1:0] phy_word,
    output logic              phy_addr_stb,
    output logic              phy_data_stb,
    output logic              phy_rd_stb,
    output logic              phy_wr_stb,
    input  logic              phy_ack,
    input  logic [WORD_W-1:0] phy_rdata
);
    localparam int unsigned IDX_W = (SCRIPT_LEN > 1) ? $clog2(SCRIPT_LEN) : 1;

    logic [IDX_W-1:0]  idx;
    rmw_entry_t        entry;
    logic              cmd_valid, cmd_ready, op_done;
    bus_op_e           cmd_op;
    logic [WORD_W-1:0] cmd_word, rd_word;
    logic [3:0]        stb;

    tune_script_rom #(.ENTRIES(SCRIPT_LEN)) u_rom (
        .idx   (idx),
        .entry (entry)
    );

    rmw_sequencer #(.ENTRIES(SCRIPT_LEN), .W(WORD_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .finished  (finished),
        .entry_idx (idx),
        .entry     (entry),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_word  (cmd_word),
        .cmd_ready (cmd_ready),
        .op_done   (op_done),
        .rd_word   (rd_word)
    );

    cr_bus_master #(.W(WORD_W)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_word  (cmd_word),
        .cmd_ready (cmd_ready),
        .op_done   (op_done),
        .rd_word   (rd_word),
        .bus_word  (phy_word),
        .bus_stb   (stb),
        .bus_ack   (phy_ack),
        .bus_rdata (phy_rdata)
    );

    assign phy_addr_stb = stb[OP_ADDR];
    assign phy_data_stb = stb[OP_DATA];
    assign phy_rd_stb   = stb[OP_READ];
    assign phy_wr_stb   = stb[OP_WRITE];

    // R1: quiet bus and no finish right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!phy_addr_stb && !phy_data_stb && !phy_rd_stb && !phy_wr_stb && !finished));
endmodule

// File: tb/phy_tune_seq_tb.sv
module phy_tune_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        finished;
    logic [15:0] phy_word;
    logic        a_stb, d_stb, r_stb, w_stb;
    logic        ack = 1'b0;
    logic [15:0] rdata = 16'h0;

    always #10 clk = ~clk;

    phy_tune_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .finished(finished),
        .phy_word(phy_word), .phy_addr_stb(a_stb), .phy_data_stb(d_stb),
        .phy_rd_stb(r_stb), .phy_wr_stb(w_stb), .phy_ack(ack), .phy_rdata(rdata)
    );

    // independent expectation table (R3)
    function automatic logic [15:0] exp_addr(input int i);
        case (i) 0: return 16'h102D; 1: return 16'h1010; 2: return 16'h1006;
                 3: return 16'h1002; default: return 16'h0030; endcase
    endfunction
    function automatic logic [15:0] exp_val(input int i, input logic [15:0] v);
        case (i)
            0: return v | 16'h0080;
            1: return (v & ~16'h0FF0) | 16'h0020;
            2: return (((v & ~16'h0040) | 16'h0080) & ~16'h0700) | 16'h0300 | 16'h0800;
            3: return (v & ~16'h7FFF) | (16'd22 << 7) | 16'h007F | 16'h4000;
            default: return v & ~16'h00F0;
        endcase
    endfunction
    function automatic int find_idx(input logic [15:0] a);
        for (int i = 0; i < 5; i++) if (exp_addr(i) == a) return i;
        return -1;
    endfunction

    // PHY register model
    logic [15:0] regs [5];
    logic [15:0] preset [5];
    logic        load_req = 1'b0;
    logic [15:0] lat_addr, lat_data;
    logic        seen_addr, seen_data;
    int          dly;
    int          proto_err = 0;
    int          wr_cnt = 0;
    logic [15:0] wlog [32];

    wire any_stb = a_stb | d_stb | r_stb | w_stb;

    always @(posedge clk) begin
        if (load_req) for (int i = 0; i < 5; i++) regs[i] <= preset[i];
        if (rst) begin
            ack <= 1'b0; dly <= 0; seen_addr <= 1'b0; seen_data <= 1'b0;
        end else if (!ack && any_stb) begin
            if (dly == 0) begin
                if ((32'(a_stb) + 32'(d_stb) + 32'(r_stb) + 32'(w_stb)) != 1) proto_err <= proto_err + 1;
                if (a_stb) begin
                    lat_addr <= phy_word; seen_addr <= 1'b1; seen_data <= 1'b0;
                end
                if (d_stb) begin
                    if (!seen_addr) proto_err <= proto_err + 1;
                    lat_data <= phy_word; seen_data <= 1'b1;
                end
                if (r_stb) begin
                    if (!seen_addr || find_idx(lat_addr) < 0) proto_err <= proto_err + 1;
                    else rdata <= regs[find_idx(lat_addr)];
                    seen_addr <= 1'b0;
                end
                if (w_stb) begin
                    if (!seen_addr || !seen_data || find_idx(lat_addr) < 0) proto_err <= proto_err + 1;
                    else regs[find_idx(lat_addr)] <= lat_data;
                    if (wr_cnt < 32) wlog[wr_cnt] <= lat_addr;
                    wr_cnt <= wr_cnt + 1;
                    seen_addr <= 1'b0; seen_data <= 1'b0;
                end
                ack <= 1'b1;
                dly <= int'($urandom % 4);
            end else dly <= dly - 1;
        end else if (ack && !any_stb) begin
            if (dly == 0) begin ack <= 1'b0; dly <= int'($urandom % 4); end
            else dly <= dly - 1;
        end
    end

    // finished monitor
    int   fin_cnt = 0;
    int   fin_wide = 0;
    logic fin_prev = 1'b0;
    always @(negedge clk) begin
        if (finished) fin_cnt <= fin_cnt + 1;
        if (finished && fin_prev) fin_wide <= fin_wide + 1;
        fin_prev <= finished;
    end

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic load_regs(input logic [15:0] v0, input logic [15:0] v1, input logic [15:0] v2,
                             input logic [15:0] v3, input logic [15:0] v4);
        preset[0] = v0; preset[1] = v1; preset[2] = v2; preset[3] = v3; preset[4] = v4;
        @(negedge clk); load_req = 1'b1;
        @(negedge clk); load_req = 1'b0;
    endtask

    // one run: preset, start, optional mid-run start, check everything
    task automatic run_case(input logic [15:0] v0, input logic [15:0] v1, input logic [15:0] v2,
                            input logic [15:0] v3, input logic [15:0] v4, input bit mid_start);
        logic [15:0] init [5];
        int w0, f0, p0, guard;
        init[0] = v0; init[1] = v1; init[2] = v2; init[3] = v3; init[4] = v4;
        load_regs(v0, v1, v2, v3, v4);
        w0 = wr_cnt; f0 = fin_cnt; p0 = proto_err;
        pulse_start();
        if (mid_start) begin
            repeat (30) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;   // R7 stimulus
        end
        guard = 0;
        while (fin_cnt == f0 && guard < 2000) begin @(negedge clk); guard++; end
        repeat (40) @(negedge clk);
        chk(fin_cnt - f0 == 1, mid_start ? "R7 single finished" : "R6 single finished", fin_cnt - f0, 1);
        chk(wr_cnt - w0 == 5, mid_start ? "R7 write count" : "R2 write count", wr_cnt - w0, 5);
        chk(proto_err == p0, "R5 access order", proto_err - p0, 0);
        for (int i = 0; i < 5; i++) begin
            if (w0 + i < 32) chk(wlog[w0 + i] == exp_addr(i), "R2 order", int'(wlog[w0 + i]), int'(exp_addr(i)));
            chk(regs[i] == exp_val(i, init[i]), "R3 merged value", int'(regs[i]), int'(exp_val(i, init[i])));
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < 5; i++) begin preset[i] = 16'h0; end
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!a_stb && !d_stb && !r_stb && !w_stb, "R1 strobes in reset", {a_stb, d_stb, r_stb, w_stb}, 0);
        chk(!finished, "R1 finished in reset", finished, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(!any_stb && !finished && wr_cnt == 0, "R1 idle without start", wr_cnt, 0);

        // corner: all zeros shows set values; all ones shows clear masks
        run_case(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0);
        run_case(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
        // R7: start during a run
        run_case(16'hA5A5, 16'h5A5A, 16'h1234, 16'h8001, 16'hFF0F, 1'b1);
        // R8: back-to-back reruns with random contents
        for (int k = 0; k < 6; k++) begin
            run_case(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), k == 3);
        end
        chk(fin_cnt == 9, "R8 reruns from first entry", fin_cnt, 9);
        chk(fin_wide == 0, "R6 finished width", fin_wide, 0);
        chk(wlog[25] == 16'h102D, "R8 rerun starts at first entry", int'(wlog[25]), 16'h102D);
        chk(proto_err == 0, "R4 handshake and R9 strobe encoding", proto_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule